// File: doc/BRIEF.md
# Fault Supervisor with Soft Restart

This block decides whether a single-ended converter's main switch may be driven. It watches four digitised fault sources: supply level, reference readiness, input line level and an external shutdown level. It also owns a soft-start level that limits the PWM command. Supply and line are compared against on/off threshold pairs with hysteresis. Shutdown trips when its code falls below a threshold. The reference arrives as a ready flag.

When any source faults, the block enters fault mode. In fault mode the main output is inhibited, the gate sequencer is told to run the auxiliary switch alone, and the soft-start level is discharged by a programmable step every cycle. Recovery needs two things together: every fault has cleared, and the soft-start level has dropped below a restart threshold. Soft start then begins at zero. It climbs by a programmable step every cycle until it reaches full scale, and normal run follows.

The effective PWM command is the smaller of the error command and the soft-start level. It is forced to zero outside soft start and run.

Top module: `fault_supervisor`

## Requirements
- R1: While rst_ni is low, main_en_o and fault_o are 0, ss_cap_o is 0 and pwm_cmd_o is 0.
- R2: The supply-good flag sets on the edge after vdd_code_i >= vdd_on_thr_i and clears on the edge after vdd_code_i < vdd_off_thr_i. Between the two thresholds it holds its value. It resets to not-good.
- R3: The line-good flag follows the same hysteresis rule, using line_code_i, line_on_thr_i and line_off_thr_i. It resets to not-good.
- R4: Shutdown is faulted on the edge after shdn_code_i < shdn_thr_i. The reference is faulted on the edge after ref_ok_i is 0. Both reset to faulted.
- R5: Any registered fault, in any state, puts the block in fault mode on the next edge: fault_o = 1 and main_en_o = 0.
- R6: In fault mode ss_cap_o falls by ss_dis_step_i every cycle and saturates at 0.
- R7: The block leaves fault mode, or the initial off state, only in a cycle with no registered fault and ss_cap_o < restart_thr_i. It then enters soft start with ss_cap_o = 0.
- R8: In soft start ss_cap_o rises by ss_step_i every cycle and saturates at full scale (all ones). The block enters run on the edge after ss_cap_o equals full scale. In run, ss_cap_o holds at full scale. Steps are nonzero.
- R9: In soft start and run, pwm_cmd_o = min(err_cmd_i, ss_cap_o). In the off state and in fault mode it is 0.
- R10: main_en_o is 1 only in run. fault_o is 1 only in fault mode. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_code_i | input | CW | Digitised supply level |
| vdd_on_thr_i | input | CW | Supply turn-on threshold |
| vdd_off_thr_i | input | CW | Supply turn-off threshold |
| ref_ok_i | input | 1 | Reference ready |
| line_code_i | input | CW | Digitised line level |
| line_on_thr_i | input | CW | Line turn-on threshold |
| line_off_thr_i | input | CW | Line turn-off threshold |
| shdn_code_i | input | CW | Digitised shutdown input level |
| shdn_thr_i | input | CW | Shutdown trip threshold |
| restart_thr_i | input | CW | Soft-start level below which restart is allowed |
| ss_step_i | input | CW | Soft-start rise per cycle |
| ss_dis_step_i | input | CW | Soft-start discharge per cycle |
| err_cmd_i | input | CW | Error-loop PWM command |
| main_en_o | output | 1 | Main switch drive permitted (run) |
| fault_o | output | 1 | Fault mode flag to the gate sequencer |
| ss_cap_o | output | CW | Soft-start level |
| pwm_cmd_o | output | CW | Effective PWM command |

## Verification
On every cycle, the assertions check several invariants. Run and fault mode are mutually exclusive. Run implies a full-scale soft-start level. The effective command never exceeds either the error command or the soft-start level. A registered fault always yields fault mode one edge later. The level never rises while in fault mode. Every exit from fault mode starts at zero, from a level that was below the restart threshold.

Some properties need whole stimulus histories, and only the bench scenarios can show them. These are the exact hysteresis switching points under swept supply, line and shutdown codes, the step-exact discharge and ramp trajectories across combinations of step sizes and restart thresholds, and the cycle on which run is entered.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_FAULT = 2'd1,
    ST_SOFT  = 2'd2,
    ST_RUN   = 2'd3
  } fsup_state_e;
endpackage

// File: rtl/fsup_hyst.sv
module fsup_hyst #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] code_i,
  input  logic [CW-1:0] on_thr_i,
  input  logic [CW-1:0] off_thr_i,
  output logic          ok_o
);
  logic ok_d;

  always_comb begin
    if (ok_o) ok_d = (code_i >= off_thr_i);
    else      ok_d = (code_i >= on_thr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_o <= 1'b0;
    else         ok_o <= ok_d;
  end
endmodule

// File: rtl/fsup_monitor.sv
module fsup_monitor #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] vdd_code_i,
  input  logic [CW-1:0] vdd_on_thr_i,
  input  logic [CW-1:0] vdd_off_thr_i,
  input  logic          ref_ok_i,
  input  logic [CW-1:0] line_code_i,
  input  logic [CW-1:0] line_on_thr_i,
  input  logic [CW-1:0] line_off_thr_i,
  input  logic [CW-1:0] shdn_code_i,
  input  logic [CW-1:0] shdn_thr_i,
  output logic          fault_o
);
  localparam int unsigned NHYST = 2;

  logic [CW-1:0]    h_code [NHYST];
  logic [CW-1:0]    h_on   [NHYST];
  logic [CW-1:0]    h_off  [NHYST];
  logic [NHYST-1:0] h_ok;
  logic             ref_ok_q;
  logic             shdn_ok_q;

  assign h_code[0] = vdd_code_i;
  assign h_on[0]   = vdd_on_thr_i;
  assign h_off[0]  = vdd_off_thr_i;
  assign h_code[1] = line_code_i;
  assign h_on[1]   = line_on_thr_i;
  assign h_off[1]  = line_off_thr_i;

  for (genvar g = 0; g < NHYST; g++) begin : g_hyst
    fsup_hyst #(.CW(CW)) u_hyst (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (h_code[g]),
      .on_thr_i  (h_on[g]),
      .off_thr_i (h_off[g]),
      .ok_o      (h_ok[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_ok_q  <= 1'b0;
      shdn_ok_q <= 1'b0;
    end else begin
      ref_ok_q  <= ref_ok_i;
      shdn_ok_q <= (shdn_code_i >= shdn_thr_i);
    end
  end

  assign fault_o = !(&h_ok) || !ref_ok_q || !shdn_ok_q;
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fault_i,
  input  logic [CW-1:0] cap_i,
  input  logic [CW-1:0] restart_thr_i,
  output fsup_state_e   state_o,
  output logic          restart_o
);
  localparam logic [CW-1:0] FULL = '1;

  fsup_state_e state_d;

  always_comb begin
    state_d   = state_o;
    restart_o = 1'b0;
    if (fault_i) begin
      state_d = ST_FAULT;
    end else begin
      unique case (state_o)
        ST_OFF, ST_FAULT: begin
          if (cap_i < restart_thr_i) begin
            state_d   = ST_SOFT;
            restart_o = 1'b1;
          end
        end
        ST_SOFT: if (cap_i == FULL) state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_OFF;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/fsup_ss_cap.sv
module fsup_ss_cap
  import fsup_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fsup_state_e   state_i,
  input  logic          restart_i,
  input  logic [CW-1:0] step_i,
  input  logic [CW-1:0] dis_step_i,
  output logic [CW-1:0] cap_o
);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW:0]   sum;
  logic [CW-1:0] cap_d;

  assign sum = {1'b0, cap_o} + {1'b0, step_i};

  always_comb begin
    cap_d = cap_o;
    if (restart_i) begin
      cap_d = '0;
    end else begin
      unique case (state_i)
        ST_OFF:   cap_d = '0;
        ST_FAULT: cap_d = (cap_o > dis_step_i) ? cap_o - dis_step_i : '0;
        ST_SOFT:  cap_d = sum[CW] ? FULL : sum[CW-1:0];
        ST_RUN:   cap_d = cap_o;
        default:  cap_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_o <= '0;
    else         cap_o <= cap_d;
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] vdd_code_i,
  input  logic [CW-1:0] vdd_on_thr_i,
  input  logic [CW-1:0] vdd_off_thr_i,
  input  logic          ref_ok_i,
  input  logic [CW-1:0] line_code_i,
  input  logic [CW-1:0] line_on_thr_i,
  input  logic [CW-1:0] line_off_thr_i,
  input  logic [CW-1:0] shdn_code_i,
  input  logic [CW-1:0] shdn_thr_i,
  input  logic [CW-1:0] restart_thr_i,
  input  logic [CW-1:0] ss_step_i,
  input  logic [CW-1:0] ss_dis_step_i,
  input  logic [CW-1:0] err_cmd_i,
  output logic          main_en_o,
  output logic          fault_o,
  output logic [CW-1:0] ss_cap_o,
  output logic [CW-1:0] pwm_cmd_o
);
  logic        fault_any;
  logic        restart;
  fsup_state_e state;

  fsup_monitor #(.CW(CW)) u_mon (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .vdd_code_i     (vdd_code_i),
    .vdd_on_thr_i   (vdd_on_thr_i),
    .vdd_off_thr_i  (vdd_off_thr_i),
    .ref_ok_i       (ref_ok_i),
    .line_code_i    (line_code_i),
    .line_on_thr_i  (line_on_thr_i),
    .line_off_thr_i (line_off_thr_i),
    .shdn_code_i    (shdn_code_i),
    .shdn_thr_i     (shdn_thr_i),
    .fault_o        (fault_any)
  );

  fsup_ctrl #(.CW(CW)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_i       (fault_any),
    .cap_i         (ss_cap_o),
    .restart_thr_i (restart_thr_i),
    .state_o       (state),
    .restart_o     (restart)
  );

  fsup_ss_cap #(.CW(CW)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .restart_i  (restart),
    .step_i     (ss_step_i),
    .dis_step_i (ss_dis_step_i),
    .cap_o      (ss_cap_o)
  );

  logic active;
  assign active    = (state == ST_SOFT) || (state == ST_RUN);
  assign main_en_o = (state == ST_RUN);
  assign fault_o   = (state == ST_FAULT);
  assign pwm_cmd_o = !active ? '0 : (err_cmd_i < ss_cap_o) ? err_cmd_i : ss_cap_o;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fault_any,
  input logic          main_en_o,
  input logic          fault_o,
  input logic [CW-1:0] ss_cap_o,
  input logic [CW-1:0] pwm_cmd_o,
  input logic [CW-1:0] err_cmd_i,
  input logic [CW-1:0] restart_thr_i
);
  localparam logic [CW-1:0] FULL = '1;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_RUN_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_en_o && fault_o)); // R10

  AST_FAULT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any |=> (fault_o && !main_en_o)); // R5

  AST_RUN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_en_o |-> ss_cap_o == FULL); // R8

  AST_CMD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_cmd_o <= ss_cap_o) && (pwm_cmd_o <= err_cmd_i)); // R9

  AST_DISCHARGE_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && fault_o && $past(fault_o)) |-> ss_cap_o <= $past(ss_cap_o)); // R6

  AST_RESTART_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(fault_o)) |->
      (ss_cap_o == '0 && $past(ss_cap_o) < $past(restart_thr_i))); // R7
endmodule

bind fault_supervisor fsup_checker #(.CW(CW)) u_fsup_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fault_any     (fault_any),
  .main_en_o     (main_en_o),
  .fault_o       (fault_o),
  .ss_cap_o      (ss_cap_o),
  .pwm_cmd_o     (pwm_cmd_o),
  .err_cmd_i     (err_cmd_i),
  .restart_thr_i (restart_thr_i)
);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
  localparam int CW = 8;
  localparam int FULL = (1 << CW) - 1;
  localparam int M_OFF = 0, M_FLT = 1, M_SS = 2, M_RUN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [CW-1:0] vdd, vdd_on, vdd_off, line, line_on, line_off, shdn, shdn_thr;
  logic [CW-1:0] rthr, step, dstep, err;
  logic ref_ok;
  logic main_en, fault;
  logic [CW-1:0] cap, pwm;

  fault_supervisor #(.CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .vdd_code_i(vdd), .vdd_on_thr_i(vdd_on), .vdd_off_thr_i(vdd_off),
    .ref_ok_i(ref_ok),
    .line_code_i(line), .line_on_thr_i(line_on), .line_off_thr_i(line_off),
    .shdn_code_i(shdn), .shdn_thr_i(shdn_thr),
    .restart_thr_i(rthr), .ss_step_i(step), .ss_dis_step_i(dstep),
    .err_cmd_i(err),
    .main_en_o(main_en), .fault_o(fault), .ss_cap_o(cap), .pwm_cmd_o(pwm)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_st, m_cap;
  bit m_vdd, m_line, m_ref, m_sd;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    int e_pwm;
    e_pwm = 0;
    if (m_st == M_SS || m_st == M_RUN) e_pwm = (int'(err) < m_cap) ? int'(err) : m_cap;
    chk("R10 main_en", int'(main_en), int'(m_st == M_RUN));
    chk("R5 fault_o", int'(fault), int'(m_st == M_FLT));
    chk("R6/R8 ss_cap", int'(cap), m_cap);
    chk("R9 pwm_cmd", int'(pwm), e_pwm);
  endtask

  task automatic tick();
    bit flt;
    int nst, ncap;
    flt = !(m_vdd && m_line && m_ref && m_sd);
    nst = m_st;
    ncap = m_cap;
    if (flt) nst = M_FLT;
    else if (m_st == M_OFF || m_st == M_FLT) begin
      if (m_cap < int'(rthr)) nst = M_SS;   // R7
    end else if (m_st == M_SS && m_cap == FULL) nst = M_RUN;
    if ((m_st == M_OFF || m_st == M_FLT) && nst == M_SS) ncap = 0;
    else if (m_st == M_OFF) ncap = 0;
    else if (m_st == M_FLT) ncap = (m_cap > int'(dstep)) ? m_cap - int'(dstep) : 0;
    else if (m_st == M_SS) ncap = (m_cap + int'(step) > FULL) ? FULL : m_cap + int'(step);
    m_vdd  = m_vdd  ? (vdd  >= vdd_off)  : (vdd  >= vdd_on);   // R2
    m_line = m_line ? (line >= line_off) : (line >= line_on);  // R3
    m_ref  = ref_ok;                                           // R4
    m_sd   = (shdn >= shdn_thr);                               // R4
    m_st = nst;
    m_cap = ncap;
    @(posedge clk);
    #1;
    check_outs();
  endtask

  task automatic run_until_run(input int limit);
    for (int i = 0; i < limit && m_st != M_RUN; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vdd = 0; vdd_on = 150; vdd_off = 85;
    line = 60; line_on = 50; line_off = 45;
    shdn = 20; shdn_thr = 5; ref_ok = 1'b1;
    rthr = 5; step = 16; dstep = 8; err = 100;
    m_st = M_OFF; m_cap = 0; m_vdd = 0; m_line = 0; m_ref = 0; m_sd = 0;
    #12;
    check_outs(); // R1 reset state
    chk("R1 reset cap", int'(cap), 0);
    rst_n = 1'b1;
    #1;

    // R2: supply sweep up then down across the hysteresis band
    for (int c = 0; c <= FULL; c++) begin vdd = c[CW-1:0]; tick(); end
    run_until_run(100);
    chk("R8 reached run", int'(main_en), 1);
    for (int c = FULL; c >= 0; c--) begin vdd = c[CW-1:0]; tick(); end
    for (int c = 0; c <= FULL; c += 3) begin vdd = c[CW-1:0]; tick(); end
    vdd = FULL; run_until_run(200);

    // R3: line sweep down and up
    for (int c = 70; c >= 30; c--) begin line = c[CW-1:0]; tick(); end
    for (int c = 30; c <= 70; c++) begin line = c[CW-1:0]; tick(); end
    run_until_run(200);

    // R4: shutdown sweep and reference drop
    for (int c = 20; c >= 0; c--) begin shdn = c[CW-1:0]; tick(); end
    for (int c = 0; c <= 20; c++) begin shdn = c[CW-1:0]; tick(); end
    run_until_run(200);
    ref_ok = 1'b0; tick(); tick(); tick();
    chk("R4 ref fault", int'(fault), 1);
    ref_ok = 1'b1;
    run_until_run(200);

    // R9: command sweep in run
    for (int c = 0; c <= FULL; c++) begin err = c[CW-1:0]; tick(); end
    err = 200;

    // R6, R7, R8: step and threshold combinations, faults mid soft start and in run
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int s = 0; s < 3; s++) begin
          rthr  = (a == 0) ? 8'd1 : (a == 1) ? 8'd40 : (a == 2) ? 8'd128 : 8'd255;
          dstep = (b == 0) ? 8'd1 : (b == 1) ? 8'd7 : 8'd255;
          step  = (s == 0) ? 8'd1 : (s == 1) ? 8'd5 : 8'd255;
          ref_ok = 1'b0; tick(); tick(); tick();
          ref_ok = 1'b1;
          for (int k = 0; k < 6; k++) tick();
          shdn = 0; tick(); tick();          // fault during soft start or discharge
          shdn = 20;
          run_until_run(700);
          chk("R8 run after restart", int'(main_en), 1);
        end
      end
    end

    // R9: command sweep during a slow soft start
    step = 1; dstep = 255; rthr = 10;
    ref_ok = 1'b0; tick(); tick(); tick(); ref_ok = 1'b1;
    for (int c = 0; c < 300; c++) begin err = c[CW-1:0] ^ 8'h5a; tick(); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule